// File: doc/BRIEF.md
# Clos Middle-Switch Path Allocator

This block chooses the centre switch for each new connection in a three-stage Clos fabric. The fabric has `M_SW` ingress switches of `N_PER` x `K_MID`, `K_MID` centre switches of `M_SW` x `M_SW`, and `M_SW` egress switches of `K_MID` x `N_PER`. That gives `N_PER*M_SW` ports on each side. Port `p` sits on ingress switch `p / N_PER`, and output `q` sits on egress switch `q / N_PER`.

Requests arrive on a valid/ready stream. Each request is either a connect (an input port and an output port) or a release (an input port). The block keeps two sets of busy vectors, one per ingress switch and one per egress switch. It also keeps a table, indexed by input port, that holds the centre switch and the output port of each live connection.

A connect takes the lowest-numbered centre switch that is free on both the ingress side and the egress side. It records the choice and returns the index. A release frees that centre switch on both sides. The result is sent on a response stream. The request side stalls while a response is waiting: `req_ready` is high only when no response is pending or the pending response is being taken in that cycle. A response holds its value until `rsp_ready` is seen. Moving existing connections to make room is not part of the block.

Top module: `clos_mid_alloc`

## Requirements
- R1: After reset no response is pending, `req_ready` is 1, and every centre switch is free on every side, so the first legal connect returns centre switch 0.
- R2: A connect (`req_op`=0) that is accepted on a rising edge returns, on the response registered at that same edge, the lowest-index centre switch that is free on both ingress switch `req_in/N_PER` and egress switch `req_out/N_PER`. The flags `rsp_blocked` and `rsp_error` are both 0 for such a connect.
- R3: Two live connections never share a centre switch when they start on the same ingress switch or end on the same egress switch.
- R4: When `K_MID >= 2*N_PER-1`, a legal connect is never answered with `rsp_blocked`.
- R5: A legal connect that has no common free centre switch gets `rsp_blocked`=1 and `rsp_mid`=0. All busy state and the connection table stay as they were, so a later release of that input port is an error.
- R6: A release (`req_op`=1) of a connected input port frees its centre switch on both the ingress and the egress side, and marks the input port and its output port as unconnected. The response returns the freed index with both flags at 0.
- R7: A connect whose input port or output port is already connected gets `rsp_error`=1 and `rsp_mid`=0, and nothing changes.
- R8: A release of an unconnected input port gets `rsp_error`=1. So does any request with a port number of `N_PER*M_SW` or more. Neither changes anything.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds every field stable and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with `req_valid` |
| req_op | input | 1 | 0 = connect, 1 = release |
| req_in | input | clog2(N_PER*M_SW) | Input port |
| req_out | input | clog2(N_PER*M_SW) | Output port (connect only) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_mid | output | clog2(K_MID) | Centre switch assigned or freed |
| rsp_blocked | output | 1 | No common free centre switch |
| rsp_error | output | 1 | Illegal request (port busy, unconnected, or out of range) |

## Verification
The bench builds two copies of the block. The first uses `N_PER`=2, `M_SW`=3, `K_MID`=3, which meets the strict non-blocking bound. In that copy the no-blocking guarantee is checked while ingress and egress switches fill up to `N_PER-1` connections with different centre switches. The second uses `N_PER`=2, `M_SW`=2, `K_MID`=2, where a release can leave the two sides with disjoint free sets, so a blocked response and its no-change rule become reachable.

// File: rtl/clos_pkg.sv
package clos_pkg;
  typedef enum logic {
    OP_CONNECT = 1'b0,
    OP_RELEASE = 1'b1
  } clos_op_e;
endpackage

// File: rtl/clos_prio_enc.sv
module clos_prio_enc #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/clos_busy_map.sv
module clos_busy_map #(
  parameter int SW_CNT = 3,
  parameter int K_MID  = 3,
  parameter int SWW    = (SW_CNT > 1) ? $clog2(SW_CNT) : 1,
  parameter int MW     = (K_MID > 1) ? $clog2(K_MID) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [SWW-1:0]                set_sw,
  input  logic [MW-1:0]                 set_mid,
  input  logic                          clr_en,
  input  logic [SWW-1:0]                clr_sw,
  input  logic [MW-1:0]                 clr_mid,
  output logic [SW_CNT-1:0][K_MID-1:0]  busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      if (set_en) busy[set_sw][set_mid] <= 1'b1;
      if (clr_en) busy[clr_sw][clr_mid] <= 1'b0;
    end
  end

  AST_NO_SHARED_MID: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !busy[set_sw][set_mid]); // R3

  AST_FREE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> busy[clr_sw][clr_mid]); // R6
endmodule

// File: rtl/clos_mid_alloc.sv
module clos_mid_alloc
  import clos_pkg::*;
#(
  parameter int N_PER = 2,
  parameter int M_SW  = 3,
  parameter int K_MID = 3,
  parameter int NPORT = N_PER * M_SW,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  parameter int MW    = (K_MID > 1) ? $clog2(K_MID) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [PW-1:0] req_in,
  input  logic [PW-1:0] req_out,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [MW-1:0] rsp_mid,
  output logic          rsp_blocked,
  output logic          rsp_error
);
  localparam int SWW = (M_SW > 1) ? $clog2(M_SW) : 1;

  logic [M_SW-1:0][K_MID-1:0] ing_busy, egr_busy;
  logic [NPORT-1:0]           conn_vld, out_used;
  logic [MW-1:0]              conn_mid [NPORT];
  logic [PW-1:0]              conn_out [NPORT];

  logic          acc, is_conn, in_ok, out_ok;
  logic [PW-1:0] in_s, out_s, rel_out;
  logic [SWW-1:0] in_sw, out_sw, rel_osw;
  logic [K_MID-1:0] cand;
  logic          found;
  logic [MW-1:0] pick, rel_mid;
  logic          conn_err, rel_err, do_set, do_clr, blk_now;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign is_conn   = (clos_op_e'(req_op) == OP_CONNECT);

  assign in_ok  = ({1'b0, req_in}  < (PW+1)'(NPORT));
  assign out_ok = ({1'b0, req_out} < (PW+1)'(NPORT));
  assign in_s   = in_ok  ? req_in  : '0;
  assign out_s  = out_ok ? req_out : '0;

  assign in_sw   = SWW'(in_s / PW'(N_PER));
  assign out_sw  = SWW'(out_s / PW'(N_PER));
  assign rel_mid = conn_mid[in_s];
  assign rel_out = conn_out[in_s];
  assign rel_osw = SWW'(rel_out / PW'(N_PER));

  assign cand = ~ing_busy[in_sw] & ~egr_busy[out_sw];

  clos_prio_enc #(.W(K_MID), .IW(MW)) u_pick (
    .cand (cand),
    .found(found),
    .idx  (pick)
  );

  assign conn_err = !in_ok || !out_ok || conn_vld[in_s] || out_used[out_s];
  assign rel_err  = !in_ok || !conn_vld[in_s];
  assign do_set   = acc && is_conn && !conn_err && found;
  assign do_clr   = acc && !is_conn && !rel_err;
  assign blk_now  = acc && is_conn && !conn_err && !found;

  clos_busy_map #(.SW_CNT(M_SW), .K_MID(K_MID), .SWW(SWW), .MW(MW)) u_ing (
    .clk(clk), .rst_n(rst_n),
    .set_en(do_set), .set_sw(in_sw), .set_mid(pick),
    .clr_en(do_clr), .clr_sw(in_sw), .clr_mid(rel_mid),
    .busy(ing_busy)
  );

  clos_busy_map #(.SW_CNT(M_SW), .K_MID(K_MID), .SWW(SWW), .MW(MW)) u_egr (
    .clk(clk), .rst_n(rst_n),
    .set_en(do_set), .set_sw(out_sw), .set_mid(pick),
    .clr_en(do_clr), .clr_sw(rel_osw), .clr_mid(rel_mid),
    .busy(egr_busy)
  );

  // connection table, one entry per input port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_vld <= '0;
      out_used <= '0;
      for (int p = 0; p < NPORT; p++) begin
        conn_mid[p] <= '0;
        conn_out[p] <= '0;
      end
    end else if (do_set) begin
      conn_vld[in_s]  <= 1'b1;
      out_used[out_s] <= 1'b1;
      conn_mid[in_s]  <= pick;
      conn_out[in_s]  <= out_s;
    end else if (do_clr) begin
      conn_vld[in_s]    <= 1'b0;
      out_used[rel_out] <= 1'b0;
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_mid     <= '0;
      rsp_blocked <= 1'b0;
      rsp_error   <= 1'b0;
    end else if (acc) begin
      rsp_valid   <= 1'b1;
      rsp_mid     <= do_set ? pick : (do_clr ? rel_mid : '0);
      rsp_blocked <= blk_now;
      rsp_error   <= is_conn ? conn_err : rel_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |-> (!ing_busy[in_sw][pick] && !egr_busy[out_sw][pick])); // R2

  AST_FAIL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !do_set && !do_clr) |=> ($stable(ing_busy) && $stable(egr_busy) && $stable(conn_vld))); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mid) && $stable(rsp_error) && $stable(rsp_blocked))); // R9

  generate
    if (K_MID >= 2 * N_PER - 1) begin : g_strict
      AST_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_conn && !conn_err) |-> found); // R4
    end
  endgenerate
endmodule

// File: tb/sim_clos_mid_alloc.sv
module sim_clos_mid_alloc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // u0: N_PER=2 M_SW=3 K_MID=3 (strict bound holds)
  logic       v0 = 0, op0 = 0, rdy0 = 1;
  logic [2:0] in0 = 0, out0 = 0;
  logic       rr0, rv0, bl0, er0;
  logic [1:0] mid0;

  clos_mid_alloc #(.N_PER(2), .M_SW(3), .K_MID(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(rr0), .req_op(op0),
    .req_in(in0), .req_out(out0), .rsp_valid(rv0), .rsp_ready(rdy0),
    .rsp_mid(mid0), .rsp_blocked(bl0), .rsp_error(er0));

  // u1: N_PER=2 M_SW=2 K_MID=2 (blocking reachable)
  logic       v1 = 0, op1 = 0;
  logic [1:0] in1 = 0, out1 = 0;
  logic       rr1, rv1, bl1, er1;
  logic [0:0] mid1;

  clos_mid_alloc #(.N_PER(2), .M_SW(2), .K_MID(2)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rr1), .req_op(op1),
    .req_in(in1), .req_out(out1), .rsp_valid(rv1), .rsp_ready(1'b1),
    .rsp_mid(mid1), .rsp_blocked(bl1), .rsp_error(er1));

  // row: {op, in[2:0], out[2:0], mid[1:0], blocked, error}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R1 R2 first connect
    {1'b0, 3'd1, 3'd2, 2'd1, 1'b0, 1'b0},  // R2 R3 ingress 0 holds mid 0
    {1'b0, 3'd2, 3'd1, 2'd1, 1'b0, 1'b0},  // R2 R3 egress 0 holds mid 0
    {1'b0, 3'd3, 3'd3, 2'd0, 1'b0, 1'b0},  // R2 R4
    {1'b0, 3'd4, 3'd4, 2'd0, 1'b0, 1'b0},  // R2
    {1'b0, 3'd0, 3'd5, 2'd0, 1'b0, 1'b1},  // R7 input busy
    {1'b0, 3'd5, 3'd0, 2'd0, 1'b0, 1'b1},  // R7 output busy
    {1'b1, 3'd2, 3'd0, 2'd1, 1'b0, 1'b0},  // R6 release returns mid 1
    {1'b1, 3'd2, 3'd0, 2'd0, 1'b0, 1'b1},  // R8 release unconnected
    {1'b0, 3'd5, 3'd1, 2'd1, 1'b0, 1'b0},  // R6 out1 free again, R3
    {1'b0, 3'd2, 3'd5, 2'd1, 1'b0, 1'b0},  // R4 both sides n-1 busy
    {1'b0, 3'd6, 3'd0, 2'd0, 1'b0, 1'b1},  // R8 port out of range
    {1'b1, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0},  // R6
    {1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0}   // R6 mid 0 reusable
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one request; response is checked at the following negedge
  task automatic send0(input logic op, input int pi, input int po);
    @(negedge clk);
    v0 = 1; op0 = op; in0 = 3'(pi); out0 = 3'(po);
    @(negedge clk);
    v0 = 0;
  endtask

  task automatic send1(input logic op, input int pi, input int po);
    @(negedge clk);
    v1 = 1; op1 = op; in1 = 2'(pi); out1 = 2'(po);
    @(negedge clk);
    v1 = 0;
  endtask

  function automatic int pk1();
    return {rv1, bl1, er1, mid1};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", int'(rv0), 0);
    check("R1 req_ready", int'(rr0), 1);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      send0(VEC[i][10], int'(VEC[i][9:7]), int'(VEC[i][6:4]));
      check($sformatf("R2/R6/R7/R8 row %0d valid", i), int'(rv0), 1);
      check($sformatf("R2/R6/R7/R8 row %0d mid/blk/err", i),
            int'({mid0, bl0, er0}), int'(VEC[i][3:0]));
    end

    // R9 back-pressure
    @(negedge clk);
    rdy0 = 0;
    send0(1'b1, 4, 0);  // release in4 -> mid 0
    check("R9 valid held", int'(rv0), 1);
    check("R9 req_ready low", int'(rr0), 0);
    check("R6 release mid", int'(mid0), 0);
    v0 = 1; op0 = 1'b0; in0 = 3'd4; out0 = 3'd4;
    repeat (2) @(negedge clk);
    check("R9 stalled response stable", int'({rv0, mid0, er0}), 8);
    check("R9 req_ready still low", int'(rr0), 0);
    rdy0 = 1;
    @(negedge clk);
    v0 = 0;
    check("R9 stalled request taken", int'({rv0, mid0, bl0, er0}), 16);

    // R5 blocking on u1: n=2 m=2 k=2
    send1(1'b0, 0, 0);
    check("R2 u1 first", pk1(), 8);      // valid, mid0
    send1(1'b0, 2, 2);
    check("R2 u1 second", pk1(), 8);
    send1(1'b0, 3, 3);
    check("R3 u1 third", pk1(), 9);      // mid1
    send1(1'b1, 2, 0);
    check("R6 u1 release", pk1(), 8);    // frees mid0 on I1,O1
    send1(1'b0, 1, 2);                   // I0 {0}, O1 {1}
    check("R5 u1 blocked", pk1(), 12);
    send1(1'b1, 1, 0);
    check("R5 u1 nothing recorded", pk1(), 10);
    send1(1'b0, 1, 1);                   // I0 {0}, O0 {0} -> 1
    check("R5 u1 state unchanged", pk1(), 9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule